// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block produces eight edge-aligned pulse-width-modulated outputs from a single up-counter. The counter steps on one of three selectable tick sources after a power-of-two prescaler. It runs from a programmable start value up to a programmable modulus and then returns to the start value. Every channel compares the counter against its own compare value. It drives its pin active from the wrap until the counter reaches that value. Each pin can be inverted and masked on its own.

Software programs the block through a single-cycle register write port and a combinational read port. Most configuration registers sit behind a lock flag, which is set after reset and must be cleared explicitly before those writes land. The modulus and compare values are double-buffered. A running period is never cut short, because new values are copied in only at a wrap or while the counter is stopped.

Top module: `pwm8_timer`

## Requirements
- R1: After reset every pin is 0, the mask register reads 0xFF, the lock flag reads 1, the counter reads 0, the counter is stopped, and the modulus shadow reads 0xFFFF.
- R2: Config register (address 0) bits [1:0] select the tick source. 0 stops the counter and holds it at the start value. 1 ticks on every clock, 2 ticks on each cycle with `tick_fixed` high, and 3 ticks on each cycle with `tick_ext` high.
- R3: Config bits [4:2] hold a prescale exponent p from 0 to 7. The counter advances once every 2^p source ticks.
- R4: The counter (read at address 1) rises by one per prescaled tick. On the tick where it is at or above the active modulus, it loads the start value (address 3) instead. With start 0, the period is modulus+1 ticks.
- R5: A channel whose control register (address 8+n) bits [1:0] are 2'b11 has an active level while the counter is below its active compare value, and an inactive level otherwise. Any other control value keeps the channel inactive.
- R6: A compare value of 0 gives a constantly inactive channel. A compare value above the modulus gives a constantly active channel.
- R7: Mask register (address 4) bit n set forces `pwm_out[n]` to 0, whatever the channel state.
- R8: Invert register (address 5) bit n set makes `pwm_out[n]` the complement of the channel's active level when unmasked.
- R9: While the lock flag is 1, writes to config, modulus, start, invert and channel control registers are dropped. Mask and compare writes always land. Writing bit0=1 to address 7 clears the flag, and writing bit0=1 to address 6 sets it. Address 6 reads the flag.
- R10: Writes to the modulus (address 2) and compare (address 16+n) registers go to shadows. The counter and comparators use those values only from the cycle after a wrap, or after any cycle in which the counter is stopped.
- R11: Reads return the shadow modulus and compare values, and the stored config, start, mask, invert and channel control values. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fixed | input | 1 | Tick strobe for source 2 |
| tick_ext | input | 1 | Tick strobe for source 3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| pwm_out | output | 8 | Channel output pins |

## Verification
The bound checker covers these properties on every cycle:
- a stopped counter holds the start value;
- the counter moves only on a prescaled tick, and then either increments or returns to the start;
- a locked modulus write leaves the shadow untouched;
- the active modulus changes only at a wrap or while stopped;
- masked pins stay low.

Duty ratios, the per-source and per-prescaler period lengths, inversion, the out-of-range compare cases and the one-period delay of a modulus update depend on whole sequences of ticks. Only the bench scenarios, checked against a cycle-level reference model, can show those.

// File: rtl/pwm8_timer.sv
module pwm8_timer #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int PSW = 3,
  parameter int AW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_fixed,
  input  logic          tick_ext,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  output logic [NCH-1:0] pwm_out
);
  localparam int IW  = $clog2(NCH);
  localparam int PDW = (1 << PSW) - 1;
  localparam int RW  = AW - IW;

  logic [1:0]     clk_sel;
  logic [PSW-1:0] ps;
  logic [CW-1:0]  mod_sh, mod_act, start, cnt;
  logic [NCH-1:0] mask, inv;
  logic           wp;
  logic [PDW-1:0] pcnt, ps_lim;
  logic [1:0]     ch_mode [NCH];
  logic [CW-1:0]  cmp_sh  [NCH];
  logic [CW-1:0]  cmp_act [NCH];
  logic           src_tick, step, wrap, load;

  assign ps_lim   = PDW'({PDW{1'b1}} >> (PDW - int'(ps)));
  assign src_tick = (clk_sel == 2'd1) | ((clk_sel == 2'd2) & tick_fixed) |
                    ((clk_sel == 2'd3) & tick_ext);
  assign step     = src_tick & (pcnt >= ps_lim);
  assign wrap     = step & (cnt >= mod_act);
  assign load     = (clk_sel == 2'd0) | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel <= '0;
      ps      <= '0;
      mod_sh  <= '1;
      mod_act <= '1;
      start   <= '0;
      cnt     <= '0;
      pcnt    <= '0;
      mask    <= '1;
      inv     <= '0;
      wp      <= 1'b1;
      for (int i = 0; i < NCH; i++) begin
        ch_mode[i] <= '0;
        cmp_sh[i]  <= '0;
        cmp_act[i] <= '0;
      end
    end else begin
      if (clk_sel == 2'd0) begin
        cnt  <= start;
        pcnt <= '0;
      end else if (src_tick) begin
        pcnt <= step ? '0 : pcnt + 1'b1;
        if (step) cnt <= wrap ? start : cnt + 1'b1;
      end
      if (load) begin
        mod_act <= mod_sh;
        for (int i = 0; i < NCH; i++) cmp_act[i] <= cmp_sh[i];
      end
      if (wr_en) begin
        if (wr_addr[AW-1:IW] == RW'(1)) begin
          if (!wp) ch_mode[wr_addr[IW-1:0]] <= wr_data[1:0];
        end else if (wr_addr[AW-1:IW] == RW'(2)) begin
          cmp_sh[wr_addr[IW-1:0]] <= wr_data;
        end else if (wr_addr[AW-1:IW] == RW'(0)) begin
          case (wr_addr[2:0])
            3'd0: if (!wp) {ps, clk_sel} <= wr_data[PSW+1:0];
            3'd2: if (!wp) mod_sh <= wr_data;
            3'd3: if (!wp) start <= wr_data;
            3'd4: mask <= wr_data[NCH-1:0];
            3'd5: if (!wp) inv <= wr_data[NCH-1:0];
            3'd6: if (wr_data[0]) wp <= 1'b1;
            3'd7: if (wr_data[0]) wp <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[AW-1:IW] == RW'(1))
      rd_data = CW'(ch_mode[rd_addr[IW-1:0]]);
    else if (rd_addr[AW-1:IW] == RW'(2))
      rd_data = cmp_sh[rd_addr[IW-1:0]];
    else if (rd_addr[AW-1:IW] == RW'(0)) begin
      case (rd_addr[2:0])
        3'd0: rd_data = CW'({ps, clk_sel});
        3'd1: rd_data = cnt;
        3'd2: rd_data = mod_sh;
        3'd3: rd_data = start;
        3'd4: rd_data = CW'(mask);
        3'd5: rd_data = CW'(inv);
        3'd6: rd_data = CW'(wp);
        default: rd_data = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic act;
    assign act        = (ch_mode[g] == 2'b11) & (cnt < cmp_act[g]);
    assign pwm_out[g] = ~mask[g] & (act ^ inv[g]);
  end
endmodule

module pwm8_timer_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     clk_sel,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  start,
  input logic [CW-1:0]  mod_act,
  input logic [CW-1:0]  mod_sh,
  input logic           step,
  input logic           wp,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] mask
);
  AST_STOP_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd0) |=> (cnt == $past(start))); // R2
  AST_NO_STEP_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != 2'd0 && !step) |=> $stable(cnt)); // R3
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt >= mod_act) |=> (cnt == $past(start))); // R4
  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt < mod_act) |=> (cnt == $past(cnt) + 1'b1)); // R4
  AST_MASKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out & mask) == '0)); // R7
  AST_LOCKED_MOD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && wr_en && wr_addr == AW'(2)) |=> $stable(mod_sh)); // R9
  AST_MOD_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != 2'd0 && !(step && cnt >= mod_act)) |=> $stable(mod_act)); // R10
endmodule

bind pwm8_timer pwm8_timer_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .cnt(cnt), .start(start),
  .mod_act(mod_act), .mod_sh(mod_sh), .step(step), .wp(wp), .wr_en(wr_en),
  .wr_addr(wr_addr), .pwm_out(pwm_out), .mask(mask)
);

// File: tb/test_pwm8_timer.sv
module test_pwm8_timer;
  localparam int NCH = 8, CW = 16, AW = 5;

  logic clk = 0, rst_n = 0, tick_fixed = 0, tick_ext = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = AW'(1);
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data;
  logic [NCH-1:0] pwm_out;
  int n_chk = 0, n_bad = 0, cyc = 0, fdiv = 0;

  always #10 clk = ~clk;

  pwm8_timer i_pwm8_timer (
    .clk(clk), .rst_n(rst_n), .tick_fixed(tick_fixed), .tick_ext(tick_ext),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  int m_sel, m_ps, m_modsh, m_modact, m_start, m_mask, m_inv, m_wp, m_cnt, m_pcnt;
  int m_chm[NCH], m_cmpsh[NCH], m_cmpact[NCH];

  task automatic m_reset();
    m_sel = 0; m_ps = 0; m_modsh = 'hFFFF; m_modact = 'hFFFF; m_start = 0;
    m_mask = 'hFF; m_inv = 0; m_wp = 1; m_cnt = 0; m_pcnt = 0;
    for (int i = 0; i < NCH; i++) begin m_chm[i] = 0; m_cmpsh[i] = 0; m_cmpact[i] = 0; end
  endtask

  function automatic int m_read(int a);
    if (a >= 8 && a < 16) return m_chm[a-8];
    if (a >= 16 && a < 24) return m_cmpsh[a-16];
    case (a)
      0: return m_sel | (m_ps << 2);
      1: return m_cnt;
      2: return m_modsh;
      3: return m_start;
      4: return m_mask;
      5: return m_inv;
      6: return m_wp;
      default: return 0;
    endcase
  endfunction

  function automatic int m_out();
    int o = 0;
    for (int i = 0; i < NCH; i++) begin
      int act = (m_chm[i] == 3 && m_cnt < m_cmpact[i]) ? 1 : 0;
      int b = ((m_mask >> i) & 1) ? 0 : (act ^ ((m_inv >> i) & 1));
      o |= b << i;
    end
    return o;
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int tk, lim, stp, wrp, a, d;
      tk  = (m_sel == 1) || (m_sel == 2 && tick_fixed) || (m_sel == 3 && tick_ext);
      lim = (1 << m_ps) - 1;
      stp = tk && (m_pcnt >= lim);
      wrp = stp && (m_cnt >= m_modact);
      if (m_sel == 0 || wrp) begin
        m_modact = m_modsh;
        for (int i = 0; i < NCH; i++) m_cmpact[i] = m_cmpsh[i];
      end
      if (m_sel == 0) begin m_cnt = m_start; m_pcnt = 0; end
      else if (tk) begin
        m_pcnt = stp ? 0 : m_pcnt + 1;
        if (stp) m_cnt = wrp ? m_start : m_cnt + 1;
      end
      if (wr_en) begin
        a = int'(wr_addr); d = int'(wr_data);
        if (a >= 8 && a < 16) begin if (!m_wp) m_chm[a-8] = d & 3; end
        else if (a >= 16 && a < 24) m_cmpsh[a-16] = d;
        else case (a)
          0: if (!m_wp) begin m_sel = d & 3; m_ps = (d >> 2) & 7; end
          2: if (!m_wp) m_modsh = d;
          3: if (!m_wp) m_start = d;
          4: m_mask = d & 'hFF;
          5: if (!m_wp) m_inv = d & 'hFF;
          6: if (d & 1) m_wp = 1;
          7: if (d & 1) m_wp = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(int'(pwm_out) == m_out(), "R5 R6 R7 R8 pwm_out per cycle", int'(pwm_out), m_out());
      check(int'(rd_data) == m_read(int'(rd_addr)), "R2 R3 R4 R10 R11 rd_data per cycle",
            int'(rd_data), m_read(int'(rd_addr)));
    end
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    #2;
    fdiv = (fdiv == 2) ? 0 : fdiv + 1;
    tick_fixed = (fdiv == 0);
    tick_ext = 1'($urandom % 2);
  end

  task automatic wr(int a, int d);
    @(negedge clk); #2;
    wr_en = 1; wr_addr = a[AW-1:0]; wr_data = d[CW-1:0];
    @(negedge clk); #2;
    wr_en = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); #2;
    rd_addr = a[AW-1:0]; #1;
    d = int'(rd_data);
  endtask

  task automatic duty(int ch, int len, output int hi);
    hi = 0;
    repeat (len) begin @(negedge clk); #3; hi += int'(pwm_out[ch]); end
  endtask

  initial begin
    int v, h, mn, mx;
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    // R1 reset state
    check(pwm_out == '0, "R1 pins low", int'(pwm_out), 0);
    rd(6, v); check(v == 1, "R1 lock set", v, 1);
    rd(4, v); check(v == 'hFF, "R1 mask", v, 'hFF);
    rd(1, v); check(v == 0, "R1 count", v, 0);
    rd(2, v); check(v == 'hFFFF, "R1 modulus", v, 'hFFFF);
    // R9 locked writes are dropped
    wr(2, 9); rd(2, v); check(v == 'hFFFF, "R9 locked modulus", v, 'hFFFF);
    wr(7, 1); rd(6, v); check(v == 0, "R9 unlock", v, 0);
    wr(2, 9); wr(3, 0);
    wr(8, 3); wr(16, 4);
    wr(9, 3); wr(17, 0);
    wr(10, 3); wr(18, 20);
    wr(11, 3); wr(19, 5); wr(5, 'h08);
    wr(12, 0); wr(20, 5);
    wr(13, 3); wr(21, 5);
    wr(4, 'hE0);
    wr(0, 1);
    repeat (30) @(negedge clk);
    duty(0, 10, h); check(h == 4, "R5 ch0 duty", h, 4);
    duty(1, 10, h); check(h == 0, "R6 compare zero", h, 0);
    duty(2, 10, h); check(h == 10, "R6 compare above modulus", h, 10);
    duty(3, 10, h); check(h == 5, "R8 inverted ch3", h, 5);
    duty(4, 10, h); check(h == 0, "R5 ch4 not in PWM mode", h, 0);
    duty(5, 10, h); check(h == 0, "R7 masked ch5", h, 0);
    // R3 prescaler 2^2
    wr(0, 1 | (2 << 2));
    repeat (80) @(negedge clk);
    duty(0, 40, h); check(h == 16, "R3 prescaled duty", h, 16);
    // R2 fixed-tick source, ext source, stop
    wr(0, 2);
    repeat (60) @(negedge clk);
    duty(0, 30, h); check(h == 12, "R2 fixed source duty", h, 12);
    wr(0, 3);
    repeat (100) @(negedge clk);
    wr(0, 0); rd(1, v); check(v == 0, "R2 stopped at start", v, 0);
    repeat (5) @(negedge clk);
    rd(1, v); check(v == 0, "R2 stays stopped", v, 0);
    // R4 nonzero start value
    wr(3, 2); wr(2, 6); wr(0, 1);
    repeat (10) @(negedge clk);
    mn = 'hFFFF; mx = 0;
    repeat (20) begin rd(1, v); if (v < mn) mn = v; if (v > mx) mx = v; end
    check(mn == 2, "R4 min count", mn, 2);
    check(mx == 6, "R4 max count", mx, 6);
    // R10 modulus update waits for a wrap
    v = -1;
    for (int k = 0; k < 20 && v != 5; k++) rd(1, v);
    wr(2, 3);
    mx = 0;
    repeat (5) begin rd(1, v); if (v > mx) mx = v; end
    check(mx > 3, "R10 old modulus kept for current period", mx, 6);
    repeat (10) @(negedge clk);
    mx = 0;
    repeat (10) begin rd(1, v); if (v > mx) mx = v; end
    check(mx == 3, "R10 new modulus after wrap", mx, 3);
    // R11 shadow readback
    wr(16, 7); rd(16, v); check(v == 7, "R11 compare shadow", v, 7);
    rd(8, v); check(v == 3, "R11 channel control", v, 3);
    rd(24, v); check(v == 0, "R11 unused address", v, 0);
    // R9 relock and unprotected mask
    wr(6, 1); rd(6, v); check(v == 1, "R9 relock", v, 1);
    wr(5, 0); rd(5, v); check(v == 'h08, "R9 locked invert", v, 'h08);
    wr(4, 0); rd(4, v); check(v == 0, "R9 mask writable while locked", v, 0);
    repeat (20) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule